// File: doc/BRIEF.md
# Receive Character Queue with Ready Signalling

This block is the receive-side character buffer of one asynchronous serial channel. The receiver's shift path pushes each assembled character into it, together with three error flags: parity error, framing error and break. The CPU side pops characters through a single read strobe. The queue holds 32 entries and keeps every character's flags attached to it. The character at the head of the queue and its flags are driven on the outputs before the CPU reads it, so line status can be examined first.

A 2-bit configuration field selects a trigger level. The trigger-level interrupt is raised while the fill level is at or above that level. An active-low ready output supports DMA-style draining, and a mode bit chooses its rule:
- In mode 0 the ready output is low whenever at least one character is stored.
- In mode 1 it goes low only once the fill reaches the trigger level, and it then stays low until the queue is empty.

A small two-state machine produces the ready output:
- `RDY_IDLE`: the output is high.
- `RDY_HOLD`: the output is low.
- The ARM transition goes from `RDY_IDLE` to `RDY_HOLD`. In mode 0 it is taken when the next fill is non-zero; in mode 1 it is taken when the next fill is at or above the trigger level.
- The DRAIN transition goes from `RDY_HOLD` to `RDY_IDLE` when the next fill is zero.

A write into a full queue loses the character and sets a sticky overrun flag, which is cleared by a status read strobe. A flush strobe empties the queue and leaves the configuration untouched.

Top module: `rx_char_queue`

## Requirements
- R1: After reset the level is 0, `empty` is 1, `rxrdy_n` is 1, `overrun` is 0 and `trig_irq` is 0.
- R2: Characters leave in the order they were written. Up to 32 characters are held. `level` reports the stored count, updated at the clock edge of the write or read.
- R3: The head character's data byte and its parity, framing and break flags appear on `rd_data`, `head_perr`, `head_ferr` and `head_brk` whenever the queue is not empty, before the read strobe is given. Each flag travels with its own character.
- R4: A write while the queue holds 32 characters and no read happens in the same cycle is discarded: the level and the head are unchanged.
- R5: A discarded write sets `overrun`, and it stays set until a cycle with `stat_rd` high and no new discard. When a set and a clear fall in the same cycle, the set wins.
- R6: `trig_sel` values 0, 1, 2 and 3 select trigger levels of 1, 8, 16 and 28 characters. `trig_irq` is 1 exactly when `level` is at or above the selected level.
- R7: With `dma_mode` = 0, `rxrdy_n` is 0 after any clock edge that leaves at least one character stored.
- R8: With `dma_mode` = 1, `rxrdy_n` falls at the edge where the level reaches the trigger level. It then stays 0, even below the trigger, until the edge where the queue becomes empty.
- R9: `flush` empties the queue and discards a write in the same cycle. It does not change `overrun`, `trig_sel` or `dma_mode`.
- R10: A read strobe on an empty queue has no effect. A read and a write in the same cycle on a full queue keep the level at 32 and do not set `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push strobe from the receiver path |
| wr_data | input | 8 | Received character |
| wr_perr | input | 1 | Parity error flag of the character |
| wr_ferr | input | 1 | Framing error flag of the character |
| wr_brk | input | 1 | Break flag of the character |
| rd_en | input | 1 | CPU read strobe, pops the head |
| stat_rd | input | 1 | Status read strobe, clears overrun |
| flush | input | 1 | Queue reset strobe |
| trig_sel | input | 2 | Trigger level select |
| dma_mode | input | 1 | Ready rule select |
| rd_data | output | 8 | Head character |
| head_perr | output | 1 | Head parity error flag |
| head_ferr | output | 1 | Head framing error flag |
| head_brk | output | 1 | Head break flag |
| level | output | 6 | Stored character count |
| empty | output | 1 | Queue empty |
| overrun | output | 1 | Sticky overrun flag |
| trig_irq | output | 1 | Trigger-level interrupt |
| rxrdy_n | output | 1 | Active-low ready |

## Verification
The assertions assume that the strobes and the configuration are stable around the clock edge. They also assume that `trig_sel` and `dma_mode` only take effect at the next edge. The mode-0 ready property therefore looks at the mode value that was present at that edge, through `$past`.

The stimulus changes all inputs shortly after the rising edge. It mixes random pushes, pops, status reads, rare flushes and occasional configuration changes, all drawn from a fixed seed. Directed runs fill the queue to its limit, overflow it, sweep every trigger level in both ready modes, and read an empty queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned RXQ_DW = 8;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [RXQ_DW-1:0] data;
    } rxq_entry_t;

    typedef enum logic {
        RDY_IDLE = 1'b0,
        RDY_HOLD = 1'b1
    } rdy_state_t;

    function automatic int unsigned rxq_trig_level(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 1;
            2'd1:    return 8;
            2'd2:    return 16;
            default: return 28;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  rxq_entry_t                   wr_entry,
    input  logic                         rd_en,
    input  logic                         flush,
    output rxq_entry_t                   head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic [$clog2(DEPTH+1)-1:0]   count_nxt,
    output logic                         drop
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH-1);

    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          pop, push;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        pop  = rd_en && (count != '0) && !flush;
        push = wr_en && !flush && ((count != FULL_CNT) || pop);
        drop = wr_en && !flush && (count == FULL_CNT) && !pop;
        if (flush)
            count_nxt = '0;
        else
            unique case ({push, pop})
                2'b10:   count_nxt = count + 1'b1;
                2'b01:   count_nxt = count - 1'b1;
                default: count_nxt = count;
            endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_nxt;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (push) wr_ptr <= ptr_inc(wr_ptr);
                if (pop)  rd_ptr <= ptr_inc(rd_ptr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_entry;
    end

    assign head = mem[rd_ptr];

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (count == FULL_CNT) && !rd_en && !flush) |=> (count == FULL_CNT) && $stable(rd_ptr));
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
    p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (count == '0) && !wr_en && !flush) |=> (count == '0) && $stable(rd_ptr));
endmodule

// File: rtl/rxq_rdy_fsm.sv
module rxq_rdy_fsm
    import rxq_pkg::*;
#(
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dma_mode,
    input  logic [CW-1:0] trig,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] count_nxt,
    output logic          rdy_n
);
    rdy_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RDY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RDY_IDLE: begin
                if (dma_mode ? (count_nxt >= trig) : (count_nxt != '0))
                    state_d = RDY_HOLD;
            end
            RDY_HOLD: begin
                if (count_nxt == '0)
                    state_d = RDY_IDLE;
            end
            default: state_d = RDY_IDLE;
        endcase
    end

    always_comb begin
        rdy_n = (state_q != RDY_HOLD);
    end

    p_ready_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n |-> (count != '0));
    p_mode0_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((count != '0) && !$past(dma_mode)) |-> !rdy_n);
endmodule

// File: rtl/rxq_ovr.sv
module rxq_ovr (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    p_ovr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [RXQ_DW-1:0]          wr_data,
    input  logic                       wr_perr,
    input  logic                       wr_ferr,
    input  logic                       wr_brk,
    input  logic                       rd_en,
    input  logic                       stat_rd,
    input  logic                       flush,
    input  logic [1:0]                 trig_sel,
    input  logic                       dma_mode,
    output logic [RXQ_DW-1:0]          rd_data,
    output logic                       head_perr,
    output logic                       head_ferr,
    output logic                       head_brk,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       empty,
    output logic                       overrun,
    output logic                       trig_irq,
    output logic                       rxrdy_n
);
    localparam int unsigned CW = $clog2(DEPTH+1);

    rxq_entry_t    in_e, head_e;
    logic [CW-1:0] cnt, cnt_nxt, trig;
    logic          drop;

    assign in_e = '{brk: wr_brk, ferr: wr_ferr, perr: wr_perr, data: wr_data};
    assign trig = CW'(rxq_trig_level(trig_sel));

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_entry(in_e),
        .rd_en(rd_en), .flush(flush), .head(head_e), .count(cnt),
        .count_nxt(cnt_nxt), .drop(drop)
    );

    rxq_rdy_fsm #(.CW(CW)) u_rdy (
        .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .trig(trig),
        .count(cnt), .count_nxt(cnt_nxt), .rdy_n(rxrdy_n)
    );

    rxq_ovr u_ovr (
        .clk(clk), .rst_n(rst_n), .set(drop), .clr(stat_rd), .flag(overrun)
    );

    assign rd_data   = head_e.data;
    assign head_perr = head_e.perr;
    assign head_ferr = head_e.ferr;
    assign head_brk  = head_e.brk;
    assign level     = cnt;
    assign empty     = (cnt == '0);
    assign trig_irq  = (cnt >= trig);

    p_irq_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_irq |-> !empty);
endmodule

// File: tb/test_rx_char_queue.sv
module test_rx_char_queue;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, wr_perr = 0, wr_ferr = 0, wr_brk = 0;
    logic [7:0] wr_data = 0;
    logic       rd_en = 0, stat_rd = 0, flush = 0, dma_mode = 0;
    logic [1:0] trig_sel = 0;
    logic [7:0] rd_data;
    logic       head_perr, head_ferr, head_brk, empty, overrun, trig_irq, rxrdy_n;
    logic [5:0] level;

    int checks = 0;
    int errors = 0;

    logic [10:0] q[$];
    bit          m_ovr = 0;
    bit          m_hold = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_char_queue i_rx_char_queue (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk), .rd_en(rd_en),
        .stat_rd(stat_rd), .flush(flush), .trig_sel(trig_sel), .dma_mode(dma_mode),
        .rd_data(rd_data), .head_perr(head_perr), .head_ferr(head_ferr),
        .head_brk(head_brk), .level(level), .empty(empty), .overrun(overrun),
        .trig_irq(trig_irq), .rxrdy_n(rxrdy_n)
    );

    function automatic int trig_of(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 8;
            2'd2: return 16;
            default: return 28;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model of one clock edge, applied with the inputs present at that edge.
    task automatic model_edge();
        bit pop, set;
        if (flush) begin
            q.delete();
            set = 0;
        end else begin
            pop = rd_en && (q.size() > 0);
            set = wr_en && (q.size() == 32) && !pop;
            if (pop) void'(q.pop_front());
            if (wr_en && !set) q.push_back({wr_brk, wr_ferr, wr_perr, wr_data});
        end
        if (set) m_ovr = 1;
        else if (stat_rd) m_ovr = 0;
        if (m_hold && q.size() == 0) m_hold = 0;
        else if (!m_hold && (dma_mode ? (q.size() >= trig_of(trig_sel)) : (q.size() > 0))) m_hold = 1;
    endtask

    task automatic compare();
        check(level == 6'(q.size()), "R2 level", level, q.size());
        check(empty == (q.size() == 0), "R2 empty", empty, q.size() == 0);
        if (q.size() > 0)
            check({head_brk, head_ferr, head_perr, rd_data} == q[0], "R3 head entry",
                  {head_brk, head_ferr, head_perr, rd_data}, q[0]);
        check(overrun == m_ovr, "R5 overrun", overrun, m_ovr);
        check(trig_irq == (q.size() >= trig_of(trig_sel)), "R6 trig_irq", trig_irq,
              q.size() >= trig_of(trig_sel));
        check(rxrdy_n == !m_hold, dma_mode ? "R8 rxrdy_n" : "R7 rxrdy_n", rxrdy_n, !m_hold);
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        #1;
        compare();
        wr_en = 0; rd_en = 0; stat_rd = 0; flush = 0;
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] f);
        wr_en = 1; wr_data = d; {wr_brk, wr_ferr, wr_perr} = f;
        cycle();
    endtask

    task automatic pop_one();
        rd_en = 1;
        cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #(3*CLK_PERIOD) rst_n = 1'b1;
        #1;
        // R1: reset state
        check(level == 0 && empty, "R1 level/empty", level, 0);
        check(rxrdy_n == 1, "R1 rxrdy_n", rxrdy_n, 1);
        check(overrun == 0 && trig_irq == 0, "R1 overrun/irq", {overrun, trig_irq}, 0);
        @(negedge clk); #(CLK_PERIOD/2 - 4);

        // R10: read on empty
        pop_one();
        check(level == 0, "R10 empty read", level, 0);

        // R2/R3: fill to 32 with flags, mode 0
        for (int i = 0; i < 32; i++) push(8'(i * 7 + 3), 3'(i));
        check(level == 32, "R2 full level", level, 32);
        // R4/R5: overflow
        push(8'hEE, 3'b111);
        check(level == 32 && rd_data == 8'h03, "R4 drop keeps head", rd_data, 8'h03);
        check(overrun == 1, "R5 overrun set", overrun, 1);
        push(8'hEF, 3'b000);
        check(overrun == 1, "R5 overrun sticky", overrun, 1);
        // R5: set wins over clear
        wr_en = 1; wr_data = 8'h11; stat_rd = 1; cycle();
        check(overrun == 1, "R5 set beats clear", overrun, 1);
        stat_rd = 1; cycle();
        check(overrun == 0, "R5 cleared", overrun, 0);
        // R10: simultaneous read/write on full
        wr_en = 1; wr_data = 8'h55; rd_en = 1; cycle();
        check(level == 32 && overrun == 0, "R10 full rd+wr", level, 32);
        // R9: flush with a write, overrun unaffected
        push(8'h66, 3'b0);
        wr_en = 1; wr_data = 8'h77; flush = 1; cycle();
        check(level == 0 && overrun == 1 && rxrdy_n == 1, "R9 flush", {level, overrun}, 7'h01);
        stat_rd = 1; cycle();

        // R6/R8: sweep triggers in mode 1
        dma_mode = 1;
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            for (int i = 0; i < trig_of(2'(s)) - 1; i++) push(8'(i), 3'b0);
            check(rxrdy_n == 1, "R8 below trigger", rxrdy_n, 1);
            push(8'hA5, 3'b101);
            check(rxrdy_n == 0 && trig_irq == 1, "R8 reached trigger", {rxrdy_n, trig_irq}, 1);
            while (level > 1) pop_one();
            check(rxrdy_n == 0, "R8 held below trigger", rxrdy_n, 0);
            pop_one();
            check(rxrdy_n == 1, "R8 released on empty", rxrdy_n, 1);
        end

        // Random phase
        for (int n = 0; n < 6000; n++) begin
            int bias;
            bias = (n % 1000 < 500) ? 75 : 35;
            wr_en   = ($urandom_range(99) < bias);
            wr_data = 8'($urandom);
            {wr_brk, wr_ferr, wr_perr} = 3'($urandom);
            rd_en   = ($urandom_range(99) < 45);
            stat_rd = ($urandom_range(99) < 8);
            flush   = ($urandom_range(999) < 5);
            if ($urandom_range(99) < 2) trig_sel = 2'($urandom);
            if ($urandom_range(99) < 1) dma_mode = ~dma_mode;
            cycle();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule